// File: doc/BRIEF.md
# Power-Management Capability Register Block

This block holds the power-management capability structure of one function's configuration space. A strap input is sampled once after reset. When the strap is high, the block reports that a capability list exists, points the capability pointer at the power-management structure, and serves the capability header and the control/status dword. When the strap is low, all of these locations read as zero and ignore writes.

Two register ports reach the same storage, one for the local processor and one for the bus. Each port carries a request, a write flag, a dword address (byte offset bits [7:2]) and write data. Read data returns on a registered path one cycle after the request. Any write to the control/status dword while the block is enabled sets interrupt-cause bit 21, and the power-state field in bits [1:0] takes the written value. The cause bit and its mask sit at two local offsets on the same ports. The interrupt output is high while the cause bit is set and its mask bit is set.

Top module: `pm_cap_regs`

## Requirements
- R1: The strap is captured on the first rising clock edge after rst_ni goes high, and later changes of the strap have no effect until the next reset.
- R2: Dword 0x04 reads bit 20 (Status bit 4, capability list present) as the captured strap, and all its other bits read as 0.
- R3: Dword 0x34 reads 0x0000_0040 when enabled and 0 when disabled.
- R4: When enabled, dword 0x40 reads {PMC, 8'h00, 8'h01}, which is 0x0002_0001 by default. Writes to dword 0x40 are ignored.
- R5: When enabled, dword 0x44 holds a writable power state in bits [1:0] and a writable PME enable in bit 8. All its other bits read as 0, and the dword is 0 after reset.
- R6: When disabled, dwords 0x40 and 0x44 read 0 and ignore writes, and the cause bit is never set.
- R7: When enabled, any write to dword 0x44 sets bit 21 of the cause word (local offset 0x60) from the next cycle on, including a write of an unchanged value.
- R8: Writing the cause word with bit 21 = 0 clears the cause bit, and writing it with bit 21 = 1 has no effect. A dword 0x44 write in the same cycle wins over a clear.
- R9: Bit 21 of the mask word (local offset 0x64) is read/write and all its other bits read as 0. irq_o equals cause bit AND mask bit.
- R10: Both ports read and write all locations, and read data appears with rvalid one cycle after the request. When both ports write the same location in the same cycle, the bus-side value is stored.
- R11: Unmapped dword addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_pm_i | input | 1 | Power-management enable strap |
| cpu_req_i | input | 1 | Processor-side access request |
| cpu_we_i | input | 1 | Processor-side write flag |
| cpu_addr_i | input | 6 | Processor-side dword address |
| cpu_wdata_i | input | 32 | Processor-side write data |
| cpu_rdata_o | output | 32 | Processor-side read data |
| cpu_rvalid_o | output | 1 | Processor-side read data valid |
| pci_req_i | input | 1 | Bus-side access request |
| pci_we_i | input | 1 | Bus-side write flag |
| pci_addr_i | input | 6 | Bus-side dword address |
| pci_wdata_i | input | 32 | Bus-side write data |
| pci_rdata_o | output | 32 | Bus-side read data |
| pci_rvalid_o | output | 1 | Bus-side read data valid |
| irq_o | output | 1 | Power-management interrupt |

## Verification
Setting the cause bit with a power-state write and clearing it with a write of zero to the cause word can land in the same cycle. The bench drives both ports on one edge: the processor port clears the cause word while the bus port writes the control/status dword. It then requires the cause bit to read back as set and the new power state to be stored. A second pair of same-cycle writes to the control/status dword checks that the bus-side value is the one kept.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NPORT = 2;

  localparam logic [AW-1:0] A_STATUS = 6'h01;
  localparam logic [AW-1:0] A_CAPPTR = 6'h0D;
  localparam logic [AW-1:0] A_PMHDR  = 6'h10;
  localparam logic [AW-1:0] A_PMCSR  = 6'h11;
  localparam logic [AW-1:0] A_CAUSE  = 6'h18;
  localparam logic [AW-1:0] A_MASK   = 6'h19;

  localparam logic [7:0] CAP_PTR_VAL = {A_PMHDR, 2'b00};
  localparam logic [7:0] CAP_ID      = 8'h01;
  localparam logic [7:0] NEXT_NULL   = 8'h00;
  localparam int STATUS_CAP_BIT      = 20;
  localparam int PME_EN_BIT          = 8;

  typedef struct packed {
    logic          req;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } cfg_req_t;
endpackage

// File: rtl/pm_strap_latch.sv
module pm_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic pm_en_o
);
  logic armed_q, pm_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pm_en_q <= 1'b0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      pm_en_q <= strap_i;
    end
  end

  assign pm_en_o = pm_en_q;

  // R1
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(pm_en_q));
endmodule

// File: rtl/pm_csr_core.sv
module pm_csr_core
  import pm_cap_pkg::*;
#(
  parameter int CAUSE_BIT = 21
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pm_en_i,
  input  cfg_req_t req_i [NPORT],
  output logic [1:0] ps_o,
  output logic     pme_en_o,
  output logic     cause_o,
  output logic     mask_o
);
  logic [1:0] ps_q, ps_d;
  logic       pme_en_q, pme_en_d;
  logic       cause_q, cause_d;
  logic       mask_q, mask_d;
  logic       wr_pmcsr, clr_req, clr_val;
  logic       unused_wdata;

  // later port index wins: index 1 is the bus side
  always_comb begin
    ps_d     = ps_q;
    pme_en_d = pme_en_q;
    mask_d   = mask_q;
    wr_pmcsr = 1'b0;
    clr_req  = 1'b0;
    clr_val  = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (req_i[p].req && req_i[p].we) begin
        if (pm_en_i && req_i[p].addr == A_PMCSR) begin
          wr_pmcsr = 1'b1;
          ps_d     = req_i[p].wdata[1:0];
          pme_en_d = req_i[p].wdata[PME_EN_BIT];
        end
        if (req_i[p].addr == A_CAUSE) begin
          clr_req = 1'b1;
          clr_val = ~req_i[p].wdata[CAUSE_BIT];
        end
        if (req_i[p].addr == A_MASK) mask_d = req_i[p].wdata[CAUSE_BIT];
      end
    end
    if (wr_pmcsr)                cause_d = 1'b1;
    else if (clr_req && clr_val) cause_d = 1'b0;
    else                         cause_d = cause_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q     <= '0;
      pme_en_q <= 1'b0;
      cause_q  <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      ps_q     <= ps_d;
      pme_en_q <= pme_en_d;
      cause_q  <= cause_d;
      mask_q   <= mask_d;
    end
  end

  assign unused_wdata = ^{req_i[0].wdata, req_i[1].wdata};
  assign ps_o     = ps_q;
  assign pme_en_o = pme_en_q;
  assign cause_o  = cause_q;
  assign mask_o   = mask_q;

  // R7
  ps_sets_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pmcsr |=> cause_q);
  // R8
  cause_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_q) |-> $past(wr_pmcsr));
  // R6
  off_no_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pm_en_i |-> !cause_q);
  // R5
  ps_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pmcsr |=> $stable(ps_q));
endmodule

// File: rtl/pm_rd_port.sv
module pm_rd_port
  import pm_cap_pkg::*;
#(
  parameter logic [15:0] PMC_VAL = 16'h0002,
  parameter int CAUSE_BIT = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          pm_en_i,
  input  logic [1:0]    ps_i,
  input  logic          pme_en_i,
  input  logic          cause_i,
  input  logic          mask_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [DW-1:0] rd_d, rdata_q;
  logic          rvalid_q;

  always_comb begin
    rd_d = '0;
    unique case (addr_i)
      A_STATUS: rd_d[STATUS_CAP_BIT] = pm_en_i;
      A_CAPPTR: if (pm_en_i) rd_d[7:0] = CAP_PTR_VAL;
      A_PMHDR:  if (pm_en_i) rd_d = {PMC_VAL, NEXT_NULL, CAP_ID};
      A_PMCSR:  if (pm_en_i) begin
                  rd_d[1:0]        = ps_i;
                  rd_d[PME_EN_BIT] = pme_en_i;
                end
      A_CAUSE:  rd_d[CAUSE_BIT] = cause_i;
      A_MASK:   rd_d[CAUSE_BIT] = mask_i;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R6
  off_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_en_i && req_i && !we_i && addr_i == A_PMCSR) |=> rdata_o == '0);
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_cap_pkg::*;
#(
  parameter logic [15:0] PMC_VAL = 16'h0002,
  parameter int CAUSE_BIT = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_pm_i,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          cpu_rvalid_o,
  input  logic          pci_req_i,
  input  logic          pci_we_i,
  input  logic [AW-1:0] pci_addr_i,
  input  logic [DW-1:0] pci_wdata_i,
  output logic [DW-1:0] pci_rdata_o,
  output logic          pci_rvalid_o,
  output logic          irq_o
);
  cfg_req_t      reqs [NPORT];
  logic [DW-1:0] rdata [NPORT];
  logic          rvalid [NPORT];
  logic          pm_en, pme_en, cause, mask;
  logic [1:0]    ps;

  assign reqs[0] = '{req: cpu_req_i, we: cpu_we_i, addr: cpu_addr_i, wdata: cpu_wdata_i};
  assign reqs[1] = '{req: pci_req_i, we: pci_we_i, addr: pci_addr_i, wdata: pci_wdata_i};

  pm_strap_latch u_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_pm_i),
    .pm_en_o (pm_en)
  );

  pm_csr_core #(.CAUSE_BIT(CAUSE_BIT)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pm_en_i  (pm_en),
    .req_i    (reqs),
    .ps_o     (ps),
    .pme_en_o (pme_en),
    .cause_o  (cause),
    .mask_o   (mask)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pm_rd_port #(.PMC_VAL(PMC_VAL), .CAUSE_BIT(CAUSE_BIT)) u_rd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (reqs[p].req),
      .we_i     (reqs[p].we),
      .addr_i   (reqs[p].addr),
      .pm_en_i  (pm_en),
      .ps_i     (ps),
      .pme_en_i (pme_en),
      .cause_i  (cause),
      .mask_i   (mask),
      .rdata_o  (rdata[p]),
      .rvalid_o (rvalid[p])
    );
  end

  assign cpu_rdata_o  = rdata[0];
  assign cpu_rvalid_o = rvalid[0];
  assign pci_rdata_o  = rdata[1];
  assign pci_rvalid_o = rvalid[1];
  assign irq_o        = cause & mask;

  // R9
  irq_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mask && pm_en);
endmodule

// File: tb/pm_cap_regs_tb_top.sv
`timescale 1ns/1ps
module pm_cap_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b1;
  logic        c_req = 0, c_we = 0, p_req = 0, p_we = 0;
  logic [5:0]  c_addr = '0, p_addr = '0;
  logic [31:0] c_wd = '0, p_wd = '0;
  logic [31:0] c_rd, p_rd;
  logic        c_rv, p_rv, irq;

  typedef struct { string tag; logic [31:0] exp; } exp_t;
  exp_t q_cpu[$];
  exp_t q_pci[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pm_cap_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strap_pm_i(strap),
    .cpu_req_i(c_req), .cpu_we_i(c_we), .cpu_addr_i(c_addr), .cpu_wdata_i(c_wd),
    .cpu_rdata_o(c_rd), .cpu_rvalid_o(c_rv),
    .pci_req_i(p_req), .pci_we_i(p_we), .pci_addr_i(p_addr), .pci_wdata_i(p_wd),
    .pci_rdata_o(p_rd), .pci_rvalid_o(p_rv), .irq_o(irq)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected reads as results appear
  always @(negedge clk) begin
    exp_t e;
    if (c_rv) begin
      if (q_cpu.size() == 0) cmp("R10 cpu unexpected rvalid", 32'd1, 32'd0);
      else begin e = q_cpu.pop_front(); cmp(e.tag, c_rd, e.exp); end
    end
    if (p_rv) begin
      if (q_pci.size() == 0) cmp("R10 pci unexpected rvalid", 32'd1, 32'd0);
      else begin e = q_pci.pop_front(); cmp(e.tag, p_rd, e.exp); end
    end
  end

  // port 0 = cpu, 1 = pci; drive at negedge, hold across one posedge
  task automatic drive(input bit port, input bit we, input logic [5:0] a,
                       input logic [31:0] d, input logic [31:0] exp, input string tag);
    if (port == 0) begin
      c_req = 1; c_we = we; c_addr = a; c_wd = d;
      if (!we) q_cpu.push_back('{tag, exp});
    end else begin
      p_req = 1; p_we = we; p_addr = a; p_wd = d;
      if (!we) q_pci.push_back('{tag, exp});
    end
  endtask

  task automatic idle();
    @(negedge clk);
    c_req = 0; c_we = 0; p_req = 0; p_we = 0;
  endtask

  task automatic rd(input bit port, input logic [5:0] a, input logic [31:0] exp, input string tag);
    drive(port, 0, a, '0, exp, tag); idle();
  endtask

  task automatic wr(input bit port, input logic [5:0] a, input logic [31:0] d);
    drive(port, 1, a, d, '0, ""); idle();
  endtask

  task automatic do_reset(input bit s);
    strap = s;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cmp("R5 reset irq", {31'b0, irq}, 32'd0);
    do_reset(1'b1);
    rd(0, 6'h01, 32'h0010_0000, "R2 status cap bit");
    rd(0, 6'h0D, 32'h0000_0040, "R3 cap ptr");
    rd(1, 6'h10, 32'h0002_0001, "R4 pm header");
    rd(0, 6'h11, 32'h0, "R5 pmcsr reset");
    rd(1, 6'h18, 32'h0, "R7 cause reset");
    rd(0, 6'h19, 32'h0, "R9 mask reset");
    rd(0, 6'h3F, 32'h0, "R11 unmapped");
    rd(1, 6'h02, 32'h0, "R11 unmapped low");
    strap = 0; repeat (2) @(negedge clk);
    rd(0, 6'h0D, 32'h0000_0040, "R1 strap change ignored");
    rd(1, 6'h01, 32'h0010_0000, "R1 status after strap change");
    wr(1, 6'h10, 32'hFFFF_FFFF);
    rd(0, 6'h10, 32'h0002_0001, "R4 header write ignored");
    wr(0, 6'h11, 32'hFFFF_FFFF);
    rd(1, 6'h11, 32'h0000_0103, "R5 R10 pmcsr writable bits");
    rd(0, 6'h18, 32'h0020_0000, "R7 cause set by power state write");
    cmp("R9 irq masked", {31'b0, irq}, 32'd0);
    wr(1, 6'h19, 32'hFFFF_FFFF);
    rd(0, 6'h19, 32'h0020_0000, "R9 mask readback");
    cmp("R9 irq unmasked", {31'b0, irq}, 32'd1);
    wr(0, 6'h18, 32'hFFFF_FFFF);
    rd(0, 6'h18, 32'h0020_0000, "R8 write one no effect");
    wr(1, 6'h18, 32'h0);
    rd(0, 6'h18, 32'h0, "R8 write zero clears");
    cmp("R8 irq after clear", {31'b0, irq}, 32'd0);
    wr(1, 6'h11, 32'h0000_0103);
    rd(1, 6'h18, 32'h0020_0000, "R7 same value write sets cause");
    wr(0, 6'h18, 32'h0);
    // same cycle: cpu clears cause, pci writes power state
    drive(0, 1, 6'h18, 32'h0, '0, "");
    drive(1, 1, 6'h11, 32'h0000_0002, '0, "");
    idle();
    rd(0, 6'h18, 32'h0020_0000, "R8 set wins over clear");
    rd(1, 6'h11, 32'h0000_0002, "R8 pmcsr in collision");
    cmp("R9 irq after collision", {31'b0, irq}, 32'd1);
    // same cycle writes to pmcsr: pci value kept
    drive(0, 1, 6'h11, 32'h0000_0001, '0, "");
    drive(1, 1, 6'h11, 32'h0000_0100, '0, "");
    idle();
    drive(0, 0, 6'h11, '0, 32'h0000_0100, "R10 pci wins cpu read");
    drive(1, 0, 6'h11, '0, 32'h0000_0100, "R10 pci wins pci read");
    idle();
    // disabled configuration
    do_reset(1'b0);
    rd(0, 6'h01, 32'h0, "R2 status cap bit off");
    rd(1, 6'h0D, 32'h0, "R3 cap ptr off");
    rd(0, 6'h10, 32'h0, "R6 header off");
    wr(1, 6'h11, 32'h0000_0103);
    rd(0, 6'h11, 32'h0, "R6 pmcsr write ignored");
    rd(1, 6'h18, 32'h0, "R6 no cause when off");
    wr(0, 6'h19, 32'hFFFF_FFFF);
    cmp("R6 irq off", {31'b0, irq}, 32'd0);
    strap = 1; repeat (2) @(negedge clk);
    rd(0, 6'h0D, 32'h0, "R1 strap rise ignored");
    repeat (3) @(negedge clk);
    cmp("R10 cpu queue drained", q_cpu.size(), 32'd0);
    cmp("R10 pci queue drained", q_pci.size(), 32'd0);
    finish_run();
  end
endmodule